// File: doc/BRIEF.md
# ACPI Sleep-State Power Sequencer

This block is the digital core that moves a memory power subsystem between soft-off (S5), suspend-to-RAM (S3) and running (S0). It watches a chip enable, an active-low suspend request, under-voltage flags for the bias supply and for the main 5 V rail, and a comparator flag that says the soft-start node has passed its stabilized threshold. From these it drives the enables of the switching regulator, the termination regulator, the auxiliary low-voltage LDO and the standby 3.3 V LDO. It also drives the dual-rail main-switch enable, the standby P-switch drive and the soft-start charge and discharge commands.

After the bias supply leaves lockout, the sequencer ignores every logic input for a blanking interval. It then waits a further settle interval so that the soft-start node can empty. Only after that does it act on the requested sleep state. The termination and auxiliary rails are held off in S0 until the soft-start level reports the main rail as settled. All input flags pass through two-flop synchronizers. Both intervals are cycle counts of the system clock.

Top module: `acpi_pwr_seq`

## Requirements
- R1: While the synchronized bias under-voltage flag is high, the block is in its power-on state: every regulator enable, dual_en_o and ss_chg_o are 0, and sby_pdrv_o and ss_dis_o are 1. Raising bias_uv_i in any state brings the block back to this state.
- R2: Once bias under-voltage clears, the block spends BLANK_CYC cycles blanking and then WAIT_CYC cycles settling. During both it drives the S5 output pattern and ignores en_i, slp_ni and main_uv_i.
- R3: In S5 only the standby LDO is on. sby_ldo_en_o=1, sby_pdrv_o=1 and ss_dis_o=1; every other output is 0.
- R4: From S5 with en_i high, a low slp_ni moves the block to S3. A high slp_ni moves it to S0 only when main_uv_i is low; otherwise the block stays in S5.
- R5: In S0, buck_en_o, dual_en_o, sby_pdrv_o and ss_chg_o are 1, and sby_ldo_en_o and ss_dis_o are 0. term_en_o and aux_en_o follow the synchronized ss_stab_i.
- R6: slp_ni falling in S0 moves the block to S3. In S3, buck_en_o and sby_ldo_en_o are 1; term_en_o, aux_en_o, dual_en_o, sby_pdrv_o and ss_chg_o are 0; ss_dis_o follows the synchronized ss_stab_i (the node discharges down to the threshold).
- R7: From S3, a high slp_ni moves the block to S0 only while main_uv_i is low. Otherwise it stays in S3.
- R8: en_i low in S0 or S3 moves the block to S5.
- R9: A change on an input pin reaches the state, and so the outputs, on the third rising clock edge after the change, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Chip enable; low requests S5 |
| slp_ni | input | 1 | Suspend request, active low (low requests S3) |
| bias_uv_i | input | 1 | Bias supply under-voltage flag |
| main_uv_i | input | 1 | Main 5 V under-voltage flag |
| ss_stab_i | input | 1 | Soft-start level above stabilized threshold |
| buck_en_o | output | 1 | Switching regulator enable |
| term_en_o | output | 1 | Termination regulator enable |
| aux_en_o | output | 1 | Auxiliary low-voltage LDO enable |
| sby_ldo_en_o | output | 1 | Standby 3.3 V LDO enable |
| dual_en_o | output | 1 | Dual-rail main-switch enable |
| sby_pdrv_o | output | 1 | Standby P-switch gate drive (low turns the switch on) |
| ss_chg_o | output | 1 | Soft-start charge command |
| ss_dis_o | output | 1 | Soft-start discharge command |

## Verification
The bench builds the block with BLANK_CYC=20 and WAIT_CYC=10 instead of the microsecond-scale defaults. This puts the exact edge where blanking ends, the last settling cycle and the first S0 cycle within a few dozen clocks, so each can be sampled. The short intervals also let a bias drop in S0 be followed by a full second power-up inside the same run. With them, every transition among the five output patterns can be checked against a cycle count worked out from the synchronizer depth and the two interval lengths.

// File: rtl/acpi_seq_pkg.sv
package acpi_seq_pkg;

  typedef enum logic [5:0] {
    ST_POR   = 6'b000001,
    ST_BLANK = 6'b000010,
    ST_WAIT  = 6'b000100,
    ST_S5    = 6'b001000,
    ST_S3    = 6'b010000,
    ST_S0    = 6'b100000
  } seq_state_e;

  typedef struct packed {
    logic buck;
    logic term;
    logic aux;
    logic sby;
    logic dual;
    logic pdrv;
    logic chg;
    logic dis;
  } rail_ctl_t;

  localparam int FLAG_N   = 5;
  localparam int F_EN     = 0;
  localparam int F_SLP_N  = 1;
  localparam int F_BIAS   = 2;
  localparam int F_MAIN   = 3;
  localparam int F_STAB   = 4;

  // assume the worst until the flags have been sampled
  localparam logic [FLAG_N-1:0] FLAG_RST = 5'b01100;

endpackage

// File: rtl/acpi_seq_sync.sv
module acpi_seq_sync #(
  parameter int               WIDTH   = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic ff1_q, ff2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ff1_q <= RST_VAL[i];
        ff2_q <= RST_VAL[i];
      end else begin
        ff1_q <= d_i[i];
        ff2_q <= ff1_q;
      end
    end
    assign q_o[i] = ff2_q;
  end

endmodule

// File: rtl/acpi_seq_timer.sv
module acpi_seq_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             done_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/acpi_seq_fsm.sv
module acpi_seq_fsm
  import acpi_seq_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int BLANK_CYC = 16,
  parameter int WAIT_CYC  = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             slp_ni,
  input  logic             bias_uv_i,
  input  logic             main_uv_i,
  input  logic             ss_stab_i,
  input  logic             tmr_done_i,
  output logic             tmr_load_o,
  output logic [CNT_W-1:0] tmr_val_o,
  output seq_state_e       state_o,
  output rail_ctl_t        ctl_o
);

  localparam logic [CNT_W-1:0] BLANK_LD = CNT_W'(BLANK_CYC - 1);
  localparam logic [CNT_W-1:0] WAIT_LD  = CNT_W'(WAIT_CYC - 1);

  seq_state_e state_q, state_d;

  always_comb begin
    state_d    = state_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = BLANK_LD;
    unique case (state_q)
      ST_POR: begin
        if (!bias_uv_i) begin
          state_d    = ST_BLANK;
          tmr_load_o = 1'b1;
        end
      end
      ST_BLANK: begin
        if (tmr_done_i) begin
          state_d    = ST_WAIT;
          tmr_load_o = 1'b1;
          tmr_val_o  = WAIT_LD;
        end
      end
      ST_WAIT: if (tmr_done_i) state_d = ST_S5;
      ST_S5: begin
        if (en_i) begin
          if (!slp_ni)         state_d = ST_S3;
          else if (!main_uv_i) state_d = ST_S0;
        end
      end
      ST_S3: begin
        if (!en_i)                      state_d = ST_S5;
        else if (slp_ni && !main_uv_i)  state_d = ST_S0;
      end
      ST_S0: begin
        if (!en_i)        state_d = ST_S5;
        else if (!slp_ni) state_d = ST_S3;
      end
      default: state_d = ST_S5;
    endcase
    if (bias_uv_i) begin
      state_d    = ST_POR;
      tmr_load_o = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_POR;
    else         state_q <= state_d;
  end

  always_comb begin
    ctl_o = '{buck: 1'b0, term: 1'b0, aux: 1'b0, sby: 1'b0,
              dual: 1'b0, pdrv: 1'b1, chg: 1'b0, dis: 1'b1};
    unique case (state_q)
      ST_POR: ;
      ST_BLANK, ST_WAIT, ST_S5: ctl_o.sby = 1'b1;
      ST_S3: begin
        ctl_o.buck = 1'b1;
        ctl_o.sby  = 1'b1;
        ctl_o.pdrv = 1'b0;
        ctl_o.dis  = ss_stab_i;
      end
      ST_S0: begin
        ctl_o.buck = 1'b1;
        ctl_o.term = ss_stab_i;
        ctl_o.aux  = ss_stab_i;
        ctl_o.dual = 1'b1;
        ctl_o.chg  = 1'b1;
        ctl_o.dis  = 1'b0;
      end
      default: ctl_o.sby = 1'b1;
    endcase
  end

  assign state_o = state_q;

endmodule

// File: rtl/acpi_pwr_seq.sv
module acpi_pwr_seq
  import acpi_seq_pkg::*;
#(
  parameter int BLANK_CYC = 1000,
  parameter int WAIT_CYC  = 12500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic slp_ni,
  input  logic bias_uv_i,
  input  logic main_uv_i,
  input  logic ss_stab_i,
  output logic buck_en_o,
  output logic term_en_o,
  output logic aux_en_o,
  output logic sby_ldo_en_o,
  output logic dual_en_o,
  output logic sby_pdrv_o,
  output logic ss_chg_o,
  output logic ss_dis_o
);

  localparam int MAX_CYC = (BLANK_CYC > WAIT_CYC) ? BLANK_CYC : WAIT_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic [FLAG_N-1:0] flags_raw, flags_s;
  logic              tmr_load, tmr_done;
  logic [CNT_W-1:0]  tmr_val;
  seq_state_e        state;
  rail_ctl_t         ctl;

  assign flags_raw[F_EN]    = en_i;
  assign flags_raw[F_SLP_N] = slp_ni;
  assign flags_raw[F_BIAS]  = bias_uv_i;
  assign flags_raw[F_MAIN]  = main_uv_i;
  assign flags_raw[F_STAB]  = ss_stab_i;

  acpi_seq_sync #(.WIDTH(FLAG_N), .RST_VAL(FLAG_RST)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (flags_raw),
    .q_o    (flags_s)
  );

  acpi_seq_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .done_o     (tmr_done)
  );

  acpi_seq_fsm #(.CNT_W(CNT_W), .BLANK_CYC(BLANK_CYC), .WAIT_CYC(WAIT_CYC)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (flags_s[F_EN]),
    .slp_ni     (flags_s[F_SLP_N]),
    .bias_uv_i  (flags_s[F_BIAS]),
    .main_uv_i  (flags_s[F_MAIN]),
    .ss_stab_i  (flags_s[F_STAB]),
    .tmr_done_i (tmr_done),
    .tmr_load_o (tmr_load),
    .tmr_val_o  (tmr_val),
    .state_o    (state),
    .ctl_o      (ctl)
  );

  assign buck_en_o    = ctl.buck;
  assign term_en_o    = ctl.term;
  assign aux_en_o     = ctl.aux;
  assign sby_ldo_en_o = ctl.sby;
  assign dual_en_o    = ctl.dual;
  assign sby_pdrv_o   = ctl.pdrv;
  assign ss_chg_o     = ctl.chg;
  assign ss_dis_o     = ctl.dis;

endmodule

// File: rtl/acpi_pwr_seq_chk.sv
module acpi_pwr_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       bias_uv_i,
  input logic       buck_en_o,
  input logic       term_en_o,
  input logic       aux_en_o,
  input logic       sby_ldo_en_o,
  input logic       dual_en_o,
  input logic       sby_pdrv_o,
  input logic [4:0] flags_s,
  input logic [5:0] state
);

  a_r5_term_needs_main: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (term_en_o || aux_en_o) |-> (buck_en_o && dual_en_o));

  a_r6_pdrv_low_only_s3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sby_pdrv_o |-> (sby_ldo_en_o && !dual_en_o));

  a_r3_dual_sby_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dual_en_o && sby_ldo_en_o));

  a_r7_s0_needs_main_ok: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dual_en_o) |-> $past(!flags_s[3]));

  a_r1_bias_forces_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(bias_uv_i, 1) && $past(bias_uv_i, 2) && $past(bias_uv_i, 3))
      |-> (!buck_en_o && !sby_ldo_en_o && sby_pdrv_o));

  a_r9_state_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(state) == 1);

endmodule

bind acpi_pwr_seq acpi_pwr_seq_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .bias_uv_i    (bias_uv_i),
  .buck_en_o    (buck_en_o),
  .term_en_o    (term_en_o),
  .aux_en_o     (aux_en_o),
  .sby_ldo_en_o (sby_ldo_en_o),
  .dual_en_o    (dual_en_o),
  .sby_pdrv_o   (sby_pdrv_o),
  .flags_s      (flags_s),
  .state        (state)
);

// File: tb/tb_acpi_pwr_seq.sv
module tb_acpi_pwr_seq;

  localparam int B = 20;
  localparam int W = 10;

  // output pattern {buck,term,aux,sby,dual,pdrv,chg,dis}
  localparam logic [7:0] P_POR  = 8'b0000_0101;
  localparam logic [7:0] P_S5   = 8'b0001_0101;
  localparam logic [7:0] P_S0   = 8'b1000_1110;
  localparam logic [7:0] P_S0ST = 8'b1110_1110;
  localparam logic [7:0] P_S3   = 8'b1001_0000;
  localparam logic [7:0] P_S3ST = 8'b1001_0001;

  // {en, slp_n, main_uv, ss_stab, expected}
  localparam logic [11:0] VEC [12] = '{
    {4'b1100, P_S0},   {4'b1101, P_S0ST}, {4'b1001, P_S3ST}, {4'b1000, P_S3},
    {4'b1110, P_S3},   {4'b1100, P_S0},   {4'b1101, P_S0ST}, {4'b0100, P_S5},
    {4'b1000, P_S3},   {4'b0000, P_S5},   {4'b1110, P_S5},   {4'b1100, P_S0}
  };

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic en_i = 1'b1, slp_ni = 1'b1, bias_uv_i = 1'b0, main_uv_i = 1'b0, ss_stab_i = 1'b0;
  logic buck_en_o, term_en_o, aux_en_o, sby_ldo_en_o, dual_en_o, sby_pdrv_o, ss_chg_o, ss_dis_o;

  int errors = 0;
  int checks = 0;

  always #4 clk_i = ~clk_i;

  acpi_pwr_seq #(.BLANK_CYC(B), .WAIT_CYC(W)) dut (
    .clk_i, .rst_ni, .en_i, .slp_ni, .bias_uv_i, .main_uv_i, .ss_stab_i,
    .buck_en_o, .term_en_o, .aux_en_o, .sby_ldo_en_o, .dual_en_o,
    .sby_pdrv_o, .ss_chg_o, .ss_dis_o
  );

  function automatic logic [7:0] outs();
    return {buck_en_o, term_en_o, aux_en_o, sby_ldo_en_o,
            dual_en_o, sby_pdrv_o, ss_chg_o, ss_dis_o};
  endfunction

  function automatic string row_req(int i);
    case (i)
      0, 1:        return "R5";
      2, 3:        return "R6";
      4, 5, 6:     return "R7";
      7, 9:        return "R8";
      default:     return "R4";
    endcase
  endfunction

  task automatic edges(int n);
    repeat (n) @(posedge clk_i);
    #2;
  endtask

  task automatic check(string req, logic [7:0] exp);
    checks++;
    if (outs() !== exp) begin
      errors++;
      $display("FAIL %s: outputs=%b expected=%b at %0t", req, outs(), exp, $time);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1", P_POR);
    rst_ni = 1'b1;
    edges(2);
    check("R1", P_POR);
    edges(1);
    check("R2", P_S5);                // blanking, inputs ignored
    edges(B + W - 1);
    check("R2", P_S5);                // last settle cycle, still no start
    edges(1);
    check("R3", P_S5);
    edges(1);
    check("R4", P_S0);                // first S0 entry

    for (int i = 0; i < 12; i++) begin
      {en_i, slp_ni, main_uv_i, ss_stab_i} = VEC[i][11:8];
      edges(4);
      check(row_req(i), VEC[i][7:0]);
    end

    // R9: exact latency of an input change
    en_i = 1'b0;
    edges(2);
    check("R9", P_S0);
    edges(1);
    check("R9", P_S5);
    en_i = 1'b1;
    edges(4);
    check("R4", P_S0);

    // R1: bias loss in S0 and full restart
    bias_uv_i = 1'b1;
    edges(2);
    check("R9", P_S0);
    edges(1);
    check("R1", P_POR);
    bias_uv_i = 1'b0;
    edges(3);
    check("R2", P_S5);
    edges(B + W);
    check("R2", P_S5);
    edges(1);
    check("R4", P_S0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule